// File: doc/BRIEF.md
# Multiplexed-Bus Register Slave with Interrupt

This block lets an external controller reach a small register file over an 8-bit bus that carries both address and data. The controller first presents an address and drops the address-latch strobe. It then performs either a read (read strobe and chip select low) or a write (data on the bus, write strobe and chip select low). All four control strobes are asynchronous to the block. They pass through two-flop synchronizers, and their edges are found in the system clock domain. The bidirectional bus is split into an input, an output and an output enable, and a pad cell outside this block joins them.

The register file holds a sticky event status register, an interrupt enable mask and a set of scratch registers. Each event input sets its own status bit. The status bits are ANDed with the mask. When any enabled bit is set, the active-low open-drain interrupt line is pulled low, and it is released only when the status register is read. The strobes must stay stable for at least three clock cycles, and bus data must stay valid for at least three cycles after the strobe that ends a phase.

Top module: `mbus_reg_slave`

## Requirements
- R1: After reset, `ad_oe` is 0, `irq_n` is 1, and the status, mask and scratch registers all read 0x00.
- R2: The address is the value on `ad_in` when the falling edge of `ale` is detected. Values on `ad_in` before that edge, or after it, do not change the latched address.
- R3: A write stores the bus data at the latched address when the write access ends. The write access ends at the first of `wr_n` or `cs_n` returning high, whichever of the two rises first.
- R4: `ad_oe` is 1 only while `rd_n` and `cs_n` are low, `wr_n` is high and `ale` is low. While `ad_oe` is 1, `ad_out` shows the register at the latched address.
- R5: When `cs_n` is high, a write strobe changes no register and a read strobe leaves `ad_oe` at 0.
- R6: A 1 on `evt_i[i]` in a clock cycle sets bit i of the status register at address 0x00, and the bit stays set until the status register is read.
- R7: The mask register is at address 0x01. A 1 in mask bit i enables status bit i. `irq_n` is 0 exactly when some status bit and its mask bit are both 1.
- R8: When a read of address 0x00 ends, the status bits are cleared and `irq_n` returns to 1 if no enabled bit remains set.
- R9: An event that arrives in the same cycle as the clear of a status read leaves its bit set after the clear.
- R10: Writes to address 0x00 are ignored. Addresses above the scratch range read 0x00 and ignore writes.
- R11: Scratch registers at addresses 0x02 to 0x05 hold the value last written and read it back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for synchronizing and registering |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_in | input | 8 | Bus value seen from the pad (address or write data) |
| ad_out | output | 8 | Read data driven toward the pad |
| ad_oe | output | 1 | Output enable for the pad driver during a read |
| ale | input | 1 | Address latch strobe; the address is taken at its falling edge |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| evt_i | input | 8 | Event pulses, one per status bit |
| irq_n | output | 1 | Open-drain interrupt: 0 pulls the line low, 1 releases it |

## Verification
The bench runs random mixes of writes, reads, event pulses and interrupt checks against a bench model of the registers. This shows whether addresses decode to the right register and whether the mask gates the interrupt correctly. Writes end in two ways: write strobe first, or chip select first. Comparing the two shows that the commit follows whichever strobe ends the access. Directed cases cover these situations, each of which tells apart a different wrong design:
- the address changes while the latch strobe is high;
- strobes are given with chip select released;
- a read is attempted while the latch strobe is high;
- an event lands in the exact clock cycle of a status clear.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    localparam int unsigned ADDR_STATUS = 0;
    localparam int unsigned ADDR_MASK   = 1;
    localparam int unsigned ADDR_SCR0   = 2;
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int unsigned W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned N_SCR = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          wr_i,
    input  logic          rd_end_i,
    input  logic [DW-1:0] evt_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);
    localparam logic [DW-1:0] A_STAT = DW'(ADDR_STATUS);
    localparam logic [DW-1:0] A_MASK = DW'(ADDR_MASK);

    typedef struct packed {
        logic [DW-1:0]             status;
        logic [DW-1:0]             mask;
        logic [N_SCR-1:0][DW-1:0]  scr;
    } rf_t;

    rf_t  rf_d, rf_q;
    logic clr_status;

    always_comb begin
        rf_d       = rf_q;
        clr_status = rd_end_i && (addr_i == A_STAT);
        // events of the clearing cycle are ORed in after the clear
        rf_d.status = (clr_status ? '0 : rf_q.status) | evt_i;
        if (wr_i) begin
            if (addr_i == A_MASK) rf_d.mask = wdata_i;
            for (int i = 0; i < int'(N_SCR); i++) begin
                if (addr_i == DW'(ADDR_SCR0 + i)) rf_d.scr[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_STAT)      rdata_o = rf_q.status;
        else if (addr_i == A_MASK) rdata_o = rf_q.mask;
        for (int i = 0; i < int'(N_SCR); i++) begin
            if (addr_i == DW'(ADDR_SCR0 + i)) rdata_o = rf_q.scr[i];
        end
    end

    assign irq_o = |(rf_q.status & rf_q.mask);

    // R6: a set status bit stays set unless a status read clears it
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_status |=> ((rf_q.status & $past(rf_q.status)) == $past(rf_q.status)));

    // R9: every event bit is present in status on the following cycle
    p_evt_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((rf_q.status & $past(evt_i)) == $past(evt_i)));

    // R3: the mask only changes through a committed write to its address
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == A_MASK) |=> $stable(rf_q.mask));
endmodule

// File: rtl/mbus_reg_slave.sv
module mbus_reg_slave
    import mbus_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned N_SCR = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic          ale,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] evt_i,
    output logic          irq_n
);
    localparam int unsigned N_STB = 4;

    typedef struct packed {
        logic          ale_p;
        logic          wr_p;
        logic          rd_p;
        logic [DW-1:0] addr;
        logic [DW-1:0] wdat;
    } bus_st_t;

    bus_st_t          st_d, st_q;
    logic [N_STB-1:0] stb_s;
    logic             ale_s, cs_n_s, rd_n_s, wr_n_s;
    logic             wr_act, rd_act, ale_fall, commit, rd_end;
    logic [DW-1:0]    rdata;
    logic             irq;

    mbus_sync #(.W(N_STB), .RST_VAL(4'b0111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ale, cs_n, rd_n, wr_n}),
        .q     (stb_s)
    );

    assign {ale_s, cs_n_s, rd_n_s, wr_n_s} = stb_s;

    always_comb begin
        wr_act   = !wr_n_s && !cs_n_s && rd_n_s;
        rd_act   = !rd_n_s && !cs_n_s && wr_n_s && !ale_s;
        ale_fall = st_q.ale_p && !ale_s;
        commit   = st_q.wr_p && !wr_act;
        rd_end   = st_q.rd_p && !rd_act;

        st_d       = st_q;
        st_d.ale_p = ale_s;
        st_d.wr_p  = wr_act;
        st_d.rd_p  = rd_act;
        if (ale_fall) st_d.addr = ad_in;
        if (wr_act)   st_d.wdat = ad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mbus_regfile #(.DW(DW), .N_SCR(N_SCR)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (st_q.addr),
        .wdata_i  (st_q.wdat),
        .wr_i     (commit),
        .rd_end_i (rd_end),
        .evt_i    (evt_i),
        .rdata_o  (rdata),
        .irq_o    (irq)
    );

    assign ad_oe  = rd_act;
    assign ad_out = rd_act ? rdata : '0;
    assign irq_n  = !irq;

    // R2: the latched address moves only on a detected latch-strobe fall
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_fall |=> $stable(st_q.addr));

    // R8: once low, the interrupt stays low until a status read or mask write
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !(rd_end && st_q.addr == DW'(ADDR_STATUS))
                && !(commit && st_q.addr == DW'(ADDR_MASK))) |=> !irq_n);
endmodule

// File: tb/mbus_reg_slave_test.sv
module mbus_reg_slave_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic       ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] evt_i = 8'h00;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_status, m_mask;
    logic [7:0] m_scr [4];

    always #2.5 clk = ~clk;

    mbus_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .evt_i(evt_i), .irq_n(irq_n)
    );

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        if (a == 8'h00) return m_status;
        if (a == 8'h01) return m_mask;
        if (a >= 8'h02 && a <= 8'h05) return m_scr[a - 8'h02];
        return 8'h00;
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h01) m_mask = d;
        else if (a >= 8'h02 && a <= 8'h05) m_scr[a - 8'h02] = d;
    endfunction

    function automatic logic model_irq_n();
        return !(|(m_status & m_mask));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_addr(input logic [7:0] a);
        ad_in = a; ale = 1'b1; ticks(3);
        ale = 1'b0; ticks(4);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit cs_first);
        set_addr(a);
        ad_in = d; cs_n = 1'b0; wr_n = 1'b0; ticks(4);
        if (cs_first) begin cs_n = 1'b1; ticks(2); wr_n = 1'b1; end
        else          begin wr_n = 1'b1; ticks(2); cs_n = 1'b1; end
        ticks(4);
        ad_in = 8'($urandom);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d, output logic oe);
        set_addr(a);
        cs_n = 1'b0; rd_n = 1'b0; ticks(4);
        d = ad_out; oe = ad_oe;
        rd_n = 1'b1; cs_n = 1'b1; ticks(4);
    endtask

    task automatic pulse_evt(input logic [7:0] e);
        evt_i = e; ticks(1); evt_i = 8'h00; ticks(1);
        m_status = m_status | e;
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a);
        logic [7:0] d;
        logic oe;
        logic [7:0] exp;
        exp = model_rd(a);
        do_read(a, d, oe);
        chk({tag, " oe"}, 32'(oe), 32'd1);
        chk({tag, " data"}, 32'(d), 32'(exp));
        if (a == 8'h00) m_status = 8'h00;
    endtask

    initial begin
        logic [7:0] d;
        logic oe;
        void'($urandom(32'd20240611));
        m_status = 0; m_mask = 0;
        for (int i = 0; i < 4; i++) m_scr[i] = 0;
        ticks(3);
        // R1: reset state
        chk("R1 ad_oe", 32'(ad_oe), 0);
        chk("R1 irq_n", 32'(irq_n), 1);
        rst_n = 1'b1; ticks(2);
        for (int a = 0; a < 6; a++) read_chk("R1 reset value", 8'(a));

        // R11 / R3: scratch write ends with WR first, then with CS first
        do_write(8'h02, 8'hA5, 1'b0); model_wr(8'h02, 8'hA5);
        do_write(8'h05, 8'h3C, 1'b1); model_wr(8'h05, 8'h3C);
        read_chk("R11 scr0", 8'h02);
        read_chk("R3 cs-first commit", 8'h05);

        // R2: address changes while ALE high; only value at the fall counts
        ad_in = 8'h05; ale = 1'b1; ticks(2); ad_in = 8'h03; ticks(2);
        ale = 1'b0; ticks(4); ad_in = 8'h04;
        cs_n = 1'b0; wr_n = 1'b0; ad_in = 8'h77; ticks(4);
        wr_n = 1'b1; ticks(2); cs_n = 1'b1; ticks(4);
        model_wr(8'h03, 8'h77);
        read_chk("R2 latched addr", 8'h03);
        read_chk("R2 other addr untouched", 8'h05);

        // R5: strobes without chip select
        set_addr(8'h02); ad_in = 8'hFF; wr_n = 1'b0; ticks(4); wr_n = 1'b1; ticks(4);
        read_chk("R5 write without cs", 8'h02);
        set_addr(8'h02); rd_n = 1'b0; ticks(4);
        chk("R5 read without cs oe", 32'(ad_oe), 0);
        rd_n = 1'b1; ticks(4);

        // R4: no drive while ALE high or during a write
        cs_n = 1'b0; rd_n = 1'b0; ale = 1'b1; ad_in = 8'h02; ticks(4);
        chk("R4 oe with ale high", 32'(ad_oe), 0);
        ale = 1'b0; ticks(4);
        chk("R4 oe with ale low", 32'(ad_oe), 1);
        chk("R4 data", 32'(ad_out), 32'(m_scr[0]));
        rd_n = 1'b1; cs_n = 1'b1; ticks(4);
        chk("R4 oe after read", 32'(ad_oe), 0);
        set_addr(8'h02); ad_in = 8'h11; cs_n = 1'b0; wr_n = 1'b0; ticks(4);
        chk("R4 oe during write", 32'(ad_oe), 0);
        wr_n = 1'b1; cs_n = 1'b1; ticks(4); model_wr(8'h02, 8'h11);

        // R10: status write ignored, unmapped address
        do_write(8'h00, 8'hFF, 1'b0);
        read_chk("R10 status write ignored", 8'h00);
        do_write(8'h09, 8'h5A, 1'b0);
        read_chk("R10 unmapped reads zero", 8'h09);

        // R6 / R7: events with mask disabled, then enabled
        pulse_evt(8'h24); ticks(1);
        chk("R7 irq masked", 32'(irq_n), 1);
        do_write(8'h01, 8'h04, 1'b1); model_wr(8'h01, 8'h04); ticks(1);
        chk("R7 irq enabled", 32'(irq_n), 0);
        read_chk("R6 sticky status", 8'h00);
        chk("R8 irq released", 32'(irq_n), 1);

        // R9: event in the clearing cycle survives
        do_write(8'h01, 8'hFF, 1'b0); model_wr(8'h01, 8'hFF);
        pulse_evt(8'h01); ticks(1);
        chk("R7 irq before read", 32'(irq_n), 0);
        set_addr(8'h00); cs_n = 1'b0; rd_n = 1'b0; ticks(4);
        chk("R9 status before clear", 32'(ad_out), 32'h01);
        rd_n = 1'b1; cs_n = 1'b1;
        ticks(2); evt_i = 8'h80; ticks(1); evt_i = 8'h00; ticks(2);
        m_status = 8'h80;
        chk("R9 irq kept", 32'(irq_n), 0);
        read_chk("R9 event kept", 8'h00);
        chk("R8 irq after clear", 32'(irq_n), 1);

        // random mix
        for (int it = 0; it < 200; it++) begin
            int op;
            logic [7:0] a;
            op = int'($urandom % 4);
            a = 8'($urandom % 8);
            case (op)
                0: begin
                    logic [7:0] v;
                    v = 8'($urandom);
                    do_write(a, v, bit'($urandom % 2));
                    model_wr(a, v);
                end
                1: read_chk("R11 random read", a);
                2: pulse_evt(8'($urandom));
                default: begin
                    ticks(1);
                    chk("R7 random irq", 32'(irq_n), 32'(model_irq_n()));
                end
            endcase
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule